// File: doc/BRIEF.md
# Receive Output Formatter for a T1/E1 Line Receiver

This block sits at the system-side edge of a T1/E1 line receiver. Upstream logic supplies a recovered line clock (about 2.048 MHz for E1, 1.544 MHz for T1/J1), the decoded positive and negative rail pulses, a code-violation flag and a loss-of-signal flag. It also supplies the raw positive and negative rails from the data slicer. All of these arrive as synchronous levels in the fast system clock domain. From them the block builds an output clock, a pair of data pins and a LOS output. A set of static control inputs chooses the format, the clock edge on which data changes, the data polarity, and power-down.

A five-state machine tracks the phase of the output clock. The states are:
- `ST_DOWN`: powered down.
- `ST_ALIGN`: waiting for the recovered clock to be low, so the first pulse is never a runt.
- `ST_LOW` and `ST_HIGH`: the two halves of each output clock period.
- `ST_BYPASS`: slicer bypass.

The transitions are:
- Any state goes to `ST_DOWN` when power-down is asserted.
- `ST_DOWN` goes to `ST_ALIGN` once power-down is released.
- `ST_ALIGN` goes to `ST_LOW` on a low recovered clock.
- `ST_LOW` goes to `ST_HIGH` on a high recovered clock. This is the period start, and the settings are latched here.
- `ST_HIGH` goes to `ST_LOW` on a low recovered clock.
- `ST_ALIGN`, `ST_LOW` and `ST_HIGH` go to `ST_BYPASS` when the mode is 11.
- `ST_BYPASS` goes to `ST_ALIGN` when the mode leaves 11.

Every output is registered once, so it follows its inputs by one system clock.

Top module: `rxf_out_formatter`

## Requirements
- R1: After reset, rx_clk_o, rx_d0_o, rx_d1_o and los_o are all 0.
- R2: With the edge-select setting 0, the data pins change only in the system cycle in which rx_clk_o rises. They hold through the following fall.
- R3: With the edge-select setting 1, the data pins change only in the system cycle in which rx_clk_o falls. They hold through the rise.
- R4: The edge-select, invert and rail-format settings are sampled only at the start of an output clock period (rx_clk_o rising). A change made within a period has no effect until the next rise. A setting change never alters rx_clk_o.
- R5: mode_i = 00 (dual rail): rx_d0_o = rec_pos_i XOR inv_i and rx_d1_o = rec_neg_i XOR inv_i, captured on the active edge.
- R6: mode_i = 01 or 10 (single rail): rx_d0_o = (rec_pos_i OR rec_neg_i) XOR inv_i. rx_d1_o carries cv_i, active high and never inverted.
- R7: mode_i = 11 (slicer bypass): one system cycle later, rx_clk_o = slc_pos_i XOR slc_neg_i, rx_d0_o = slc_pos_i XOR inv_i and rx_d1_o = slc_neg_i XOR inv_i. The recovered clock is ignored. On leaving this mode the block goes through alignment.
- R8: With pwr_down_i = 1, all four outputs are 0 from the next system cycle on. After release, rx_clk_o stays 0 until the recovered clock has been seen low and then rises again.
- R9: While powered, los_o equals los_i of the previous system cycle.
- R10: Outside bypass and power-down, once aligned, rx_clk_o equals rec_clk_i of the previous system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rec_clk_i | input | 1 | Recovered line clock, as a synchronous level |
| rec_pos_i | input | 1 | Decoded positive rail |
| rec_neg_i | input | 1 | Decoded negative rail |
| cv_i | input | 1 | Code-violation flag |
| slc_pos_i | input | 1 | Raw slicer positive rail |
| slc_neg_i | input | 1 | Raw slicer negative rail |
| los_i | input | 1 | Loss-of-signal flag |
| mode_i | input | 2 | 00 dual, 01/10 single, 11 slicer bypass |
| edge_sel_i | input | 1 | 0 = data changes on rise, 1 = on fall |
| inv_i | input | 1 | Invert data polarity |
| pwr_down_i | input | 1 | Receive power-down |
| rx_clk_o | output | 1 | Output clock |
| rx_d0_o | output | 1 | First data pin |
| rx_d1_o | output | 1 | Second data pin (data or violation report) |
| los_o | output | 1 | Loss-of-signal output |

## Verification
The block has no size parameter; the mode field width is fixed in the package. The bench therefore builds it with its only configuration. It drives the recovered clock as hand-shaped phases a few system cycles long. This lets every state transition, every mid-period change of a setting, and power-down entry and exit in either clock phase be placed on an exact cycle and checked there.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MD_DUAL   = 2'b00,
        MD_SINGLE = 2'b01,
        MD_RSVD   = 2'b10,
        MD_BYPASS = 2'b11
    } rxf_mode_e;

    typedef enum logic [2:0] {
        ST_DOWN,
        ST_ALIGN,
        ST_LOW,
        ST_HIGH,
        ST_BYPASS
    } rxf_state_e;

    typedef struct packed {
        logic edge_fall;
        logic invert;
        logic single;
    } rxf_cfg_t;
endpackage

// File: rtl/rxf_phase_fsm.sv
module rxf_phase_fsm
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    input  logic       byp_req,
    input  logic       rec_clk,
    output rxf_state_e state_q,
    output rxf_state_e state_d,
    output logic       rise,
    output logic       fall
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (pwr_down) begin
            state_d = ST_DOWN;
        end else begin
            unique case (state_q)
                ST_DOWN:   state_d = ST_ALIGN;
                ST_ALIGN:  if (byp_req) state_d = ST_BYPASS;
                           else if (!rec_clk) state_d = ST_LOW;
                ST_LOW:    if (byp_req) state_d = ST_BYPASS;
                           else if (rec_clk) state_d = ST_HIGH;
                ST_HIGH:   if (byp_req) state_d = ST_BYPASS;
                           else if (!rec_clk) state_d = ST_LOW;
                ST_BYPASS: if (!byp_req) state_d = ST_ALIGN;
                default:   state_d = ST_DOWN;
            endcase
        end
    end

    assign rise = (state_q == ST_LOW)  && (state_d == ST_HIGH);
    assign fall = (state_q == ST_HIGH) && (state_d == ST_LOW);

    // R8/R10: a high phase is only ever entered from a low phase (no runt pulse)
    a_r8_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH) |-> ($past(state_q) == ST_LOW || $past(state_q) == ST_HIGH));

    // R8: power-down always lands in the down state
    a_r8_down_on_pd: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (state_q == ST_DOWN));
endmodule

// File: rtl/rxf_cfg_latch.sv
module rxf_cfg_latch
    import rxf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  rxf_cfg_t cfg_in,
    output rxf_cfg_t cfg_now
);
    rxf_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cfg_q <= '0;
        else if (start) cfg_q <= cfg_in;
    end

    assign cfg_now = start ? cfg_in : cfg_q;

    // R4: held settings move only at a period start
    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(cfg_q));
endmodule

// File: rtl/rxf_data_path.sv
module rxf_data_path
    import rxf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pwr_down,
    input  logic     byp_next,
    input  logic     high_next,
    input  logic     rise,
    input  logic     fall,
    input  rxf_cfg_t cfg_now,
    input  logic     inv_live,
    input  logic     rec_pos,
    input  logic     rec_neg,
    input  logic     cv,
    input  logic     slc_pos,
    input  logic     slc_neg,
    input  logic     los_in,
    output logic     clk_q,
    output logic     d0_q,
    output logic     d1_q,
    output logic     los_q
);
    logic cap;
    logic d0_fmt, d1_fmt;

    assign cap = (rise && !cfg_now.edge_fall) || (fall && cfg_now.edge_fall);

    always_comb begin
        if (cfg_now.single) begin
            d0_fmt = (rec_pos | rec_neg) ^ cfg_now.invert;
            d1_fmt = cv;
        end else begin
            d0_fmt = rec_pos ^ cfg_now.invert;
            d1_fmt = rec_neg ^ cfg_now.invert;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
            d0_q  <= 1'b0;
            d1_q  <= 1'b0;
            los_q <= 1'b0;
        end else if (pwr_down) begin
            clk_q <= 1'b0;
            d0_q  <= 1'b0;
            d1_q  <= 1'b0;
            los_q <= 1'b0;
        end else begin
            los_q <= los_in;
            if (byp_next) begin
                clk_q <= slc_pos ^ slc_neg;
                d0_q  <= slc_pos ^ inv_live;
                d1_q  <= slc_neg ^ inv_live;
            end else begin
                clk_q <= high_next;
                if (cap) begin
                    d0_q <= d0_fmt;
                    d1_q <= d1_fmt;
                end
            end
        end
    end

    // R2/R3: outside bypass and power-down, data moves only on a capture
    a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down && !byp_next && !cap) |=> ($stable(d0_q) && $stable(d1_q)));

    // R9: LOS follows with one cycle of latency while powered
    a_r9_los_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down |=> (los_q == $past(los_in)));
endmodule

// File: rtl/rxf_out_formatter.sv
module rxf_out_formatter
    import rxf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rec_clk_i,
    input  logic                rec_pos_i,
    input  logic                rec_neg_i,
    input  logic                cv_i,
    input  logic                slc_pos_i,
    input  logic                slc_neg_i,
    input  logic                los_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic                edge_sel_i,
    input  logic                inv_i,
    input  logic                pwr_down_i,
    output logic                rx_clk_o,
    output logic                rx_d0_o,
    output logic                rx_d1_o,
    output logic                los_o
);
    rxf_state_e state_q, state_d;
    logic       rise, fall, byp_req;
    rxf_cfg_t   cfg_in, cfg_now;

    assign byp_req = (mode_i == MD_BYPASS);

    assign cfg_in.edge_fall = edge_sel_i;
    assign cfg_in.invert    = inv_i;
    assign cfg_in.single    = (mode_i == MD_SINGLE) || (mode_i == MD_RSVD);

    rxf_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down_i),
        .byp_req  (byp_req),
        .rec_clk  (rec_clk_i),
        .state_q  (state_q),
        .state_d  (state_d),
        .rise     (rise),
        .fall     (fall)
    );

    rxf_cfg_latch u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (rise),
        .cfg_in  (cfg_in),
        .cfg_now (cfg_now)
    );

    rxf_data_path u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down_i),
        .byp_next  (state_d == ST_BYPASS),
        .high_next (state_d == ST_HIGH),
        .rise      (rise),
        .fall      (fall),
        .cfg_now   (cfg_now),
        .inv_live  (inv_i),
        .rec_pos   (rec_pos_i),
        .rec_neg   (rec_neg_i),
        .cv        (cv_i),
        .slc_pos   (slc_pos_i),
        .slc_neg   (slc_neg_i),
        .los_in    (los_i),
        .clk_q     (rx_clk_o),
        .d0_q      (rx_d0_o),
        .d1_q      (rx_d1_o),
        .los_q     (los_o)
    );

    // R8: power-down silences every output on the next cycle
    a_r8_pd_silent: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> !(rx_clk_o || rx_d0_o || rx_d1_o || los_o));

    // R7: in bypass the output clock is the XOR of the slicer rails
    a_r7_bypass_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down_i && byp_req && state_q == ST_BYPASS) |=> (rx_clk_o == $past(slc_pos_i ^ slc_neg_i)));

    // R10: aligned, non-bypass output clock follows the recovered clock
    a_r10_clk_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down_i && !byp_req && (state_q == ST_LOW || state_q == ST_HIGH)) |=> (rx_clk_o == $past(rec_clk_i)));
endmodule

// File: tb/rxf_out_formatter_tb.sv
module rxf_out_formatter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_clk = 0, rec_pos = 0, rec_neg = 0, cv = 0;
    logic slc_pos = 0, slc_neg = 0, los_in = 0;
    logic [1:0] mode = 2'b00;
    logic edge_sel = 0, inv = 0, pd = 0;
    logic rx_clk, rx_d0, rx_d1, los_out;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rxf_out_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .rec_clk_i(rec_clk), .rec_pos_i(rec_pos),
        .rec_neg_i(rec_neg), .cv_i(cv), .slc_pos_i(slc_pos), .slc_neg_i(slc_neg),
        .los_i(los_in), .mode_i(mode), .edge_sel_i(edge_sel), .inv_i(inv),
        .pwr_down_i(pd), .rx_clk_o(rx_clk), .rx_d0_o(rx_d0), .rx_d1_o(rx_d1),
        .los_o(los_out)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // expected order: {clk, d0, d1, los}
    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {rx_clk, rx_d0, rx_d1, los_out};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic align_low();
        rec_clk = 0;
        cyc(); cyc();
    endtask

    task automatic t_reset();
        #1;
        chk("R1 during reset", 4'b0000);
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1 after reset", 4'b0000);
    endtask

    task automatic t_rise_edge();
        mode = 2'b00; edge_sel = 0; inv = 0;
        align_low();
        rec_pos = 1; rec_neg = 0; rec_clk = 1; cyc();
        chk("R2 R5 capture on rise", 4'b1100);
        rec_pos = 0; rec_neg = 1; cyc();
        chk("R2 hold in high", 4'b1100);
        rec_clk = 0; cyc();
        chk("R2 R10 hold on fall", 4'b0100);
        rec_clk = 1; cyc();
        chk("R2 R5 next rise", 4'b1010);
    endtask

    task automatic t_fall_edge();
        rec_clk = 0; cyc();
        edge_sel = 1; rec_pos = 1; rec_neg = 1; cyc();
        rec_clk = 1; cyc();
        chk("R3 no change on rise", 4'b1010);
        rec_clk = 0; cyc();
        chk("R3 R5 capture on fall", 4'b0110);
    endtask

    task automatic t_midcycle_cfg();
        // active: fall edge, inv 0; change inv within the high phase
        rec_pos = 1; rec_neg = 0; rec_clk = 1; cyc();
        chk("R4 rise no capture", 4'b1110);
        inv = 1; cyc();
        chk("R4 clock unaffected by inv change", 4'b1110);
        rec_clk = 0; cyc();
        chk("R4 old inv used at fall", 4'b0100);
        // change edge select in low phase: sampled at next rise
        edge_sel = 0; rec_pos = 0; rec_neg = 0; cyc();
        chk("R4 clock unaffected by edge change", 4'b0100);
        rec_clk = 1; cyc();
        chk("R4 new edge and inv applied at rise", 4'b1110);
        // edge change in high phase must not act at this fall
        edge_sel = 1; rec_pos = 1; rec_neg = 1; cyc();
        rec_clk = 0; cyc();
        chk("R4 edge change held till next period", 4'b0110);
        edge_sel = 0; inv = 0;
    endtask

    task automatic t_single();
        mode = 2'b01; inv = 1; rec_clk = 0; cyc();
        rec_pos = 0; rec_neg = 1; cv = 1; rec_clk = 1; cyc();
        chk("R6 single inv OR and cv", 4'b1010);
        rec_clk = 0; cyc();
        rec_pos = 0; rec_neg = 0; cv = 0; rec_clk = 1; cyc();
        chk("R6 single inv empty", 4'b1100);
        rec_clk = 0; mode = 2'b10; inv = 0; cyc();
        rec_pos = 1; rec_neg = 0; cv = 1; rec_clk = 1; cyc();
        chk("R6 reserved mode as single", 4'b1110);
        rec_clk = 0; cv = 0; cyc();
    endtask

    task automatic t_bypass();
        mode = 2'b11; inv = 0; slc_pos = 1; slc_neg = 0; rec_clk = 0; cyc();
        chk("R7 bypass xor high", 4'b1100);
        slc_pos = 1; slc_neg = 1; rec_clk = 1; cyc();
        chk("R7 bypass xor low, rec clock ignored", 4'b0110);
        inv = 1; slc_pos = 0; slc_neg = 1; cyc();
        chk("R7 bypass inverted rails", 4'b1100);
        inv = 0; mode = 2'b00; rec_clk = 1; cyc();
        chk("R7 leave bypass realigns (clock low)", 4'b0100);
        cyc();
        chk("R7 stays aligned-wait while rec high", 4'b0100);
    endtask

    task automatic t_los_pd();
        align_low();
        los_in = 1; cyc();
        chk("R9 los follows", 4'b0101);
        rec_clk = 1; rec_pos = 1; cyc();
        pd = 1; cyc();
        chk("R8 power-down all low", 4'b0000);
        cyc();
        chk("R8 power-down held", 4'b0000);
        pd = 0; rec_clk = 1; cyc();
        chk("R8 release, los back, no clock", 4'b0001);
        cyc();
        chk("R8 no runt while rec high", 4'b0001);
        rec_clk = 0; cyc();
        los_in = 0; rec_pos = 1; rec_neg = 0; rec_clk = 1; cyc();
        chk("R8 R10 clock resumes after low", 4'b1100);
    endtask

    initial begin
        t_reset();
        t_rise_edge();
        t_fall_edge();
        t_midcycle_cfg();
        t_single();
        t_bypass();
        t_los_pd();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule